// File: doc/BRIEF.md
# Fractional SPI Bit-Rate Generator

This block makes the serial clock for an SPI master from a fast reference clock. It does not divide by an integer. A phase accumulator adds a scaled rate code on every reference cycle. The serial clock toggles on each accumulator carry, so its frequency is the reference frequency times the code, divided by 512. Legal codes are powers of two from 1 to 128. The fastest serial clock is therefore one quarter of the reference, and the slowest is 1/512 of it. Every serial clock period has a 50% duty cycle.

Each chip-select slot has its own rate code, clock polarity and clock phase. The slot picked by the select input supplies all three. While the run input is low, the serial clock rests at the idle level given by the selected polarity, and the accumulator is held at zero. After run rises, the first edge therefore arrives exactly one half-period later.

Alongside the serial clock, the block gives two one-cycle strobes. The launch strobe marks the edge on which the data path should drive new data. The capture strobe marks the edge on which it should sample. The shift register, the FIFOs and chip-select timing belong to neighbouring blocks.

Top module: `spi_rate_gen`

## Requirements
- R1: While `rst` is high, `sclk_o`, `launch_o` and `capture_o` are all 0 one cycle later, whatever the other inputs are.
- R2: While `run_i` is low, in the following cycle `sclk_o` equals the polarity bit of the selected slot and neither strobe is high.
- R3: While running with effective code N, successive `sclk_o` transitions are exactly 256/N reference cycles apart. This gives SCLK = ref × N / 512, with a period of 4 reference cycles at N=128 and 512 at N=1.
- R4: After `run_i` rises, the first `sclk_o` transition appears after exactly 256/N rising edges of `clk` at which `run_i` is sampled high.
- R5: The effective code is the highest set bit of the 8-bit slot code, kept as a single power of two. A code of 0 counts as 1, so 0x60 acts as 64 and 0xFF acts as 128.
- R6: With the selected phase bit at 0, odd-numbered transitions since run rose (1st, 3rd, …) carry `capture_o` and even-numbered transitions carry `launch_o`.
- R7: With the selected phase bit at 1, odd-numbered transitions carry `launch_o` and even-numbered transitions carry `capture_o`.
- R8: Slot k takes its rate code from `rate_codes_i[8k+7:8k]`, its polarity from `cpol_vec_i[k]` and its phase from `cpha_vec_i[k]`. Only the slot given by `cs_sel_i` has any effect on the outputs.
- R9: At most one strobe is high in any cycle. A strobe is high only in a cycle where `sclk_o` differs from its value in the previous cycle.
- R10: Dropping `run_i` for one cycle in the middle of a half-period returns `sclk_o` to the idle level and restarts the timing. The next first edge again takes the full 256/N cycles, and the edge numbering starts again at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | High while the serial clock should run |
| cs_sel_i | input | CS_W | Index of the selected chip-select slot |
| rate_codes_i | input | NUM_CS*8 | Rate code for each slot, slot k at bits 8k+7:8k |
| cpol_vec_i | input | NUM_CS | Idle clock level for each slot |
| cpha_vec_i | input | NUM_CS | Clock phase for each slot |
| sclk_o | output | 1 | Serial clock, at the idle level while stopped |
| launch_o | output | 1 | One-cycle strobe on a launch transition |
| capture_o | output | 1 | One-cycle strobe on a capture transition |

## Verification
The hardest case to reach from the ports is a restart in the middle of a half-period. In that case both the accumulator residue and the edge-parity state must be discarded. The stimulus runs a slow code partway into a half-period and drops run for a single cycle. It then checks that the next edge again takes the full 256/N cycles and is numbered as the first edge. Slot selection is covered at the same time. All slots that are not selected hold opposite polarity, opposite phase and a different code, so any lane mix-up changes the edge timing or the strobe kind.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

    localparam int CODE_W = 8;
    localparam int ACC_W  = CODE_W + 1;
    localparam int SUM_W  = ACC_W + 1;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              cpol;
        logic              cpha;
    } lane_cfg_t;

    typedef enum logic [1:0] {
        EDGE_NONE    = 2'd0,
        EDGE_LAUNCH  = 2'd1,
        EDGE_CAPTURE = 2'd2
    } edge_kind_t;

    // Keep only the highest set bit; an all-zero code becomes 1.
    function automatic logic [CODE_W-1:0] fold_code(input logic [CODE_W-1:0] raw);
        logic [CODE_W-1:0] res;
        res    = '0;
        res[0] = 1'b1;
        for (int i = 0; i < CODE_W; i++) begin
            if (raw[i]) begin
                res    = '0;
                res[i] = 1'b1;
            end
        end
        return res;
    endfunction

    // Phase of the transition: odd-numbered edges capture when phase is 0.
    function automatic edge_kind_t classify_edge(input logic odd_edge, input logic cpha);
        return (odd_edge ^ cpha) ? EDGE_CAPTURE : EDGE_LAUNCH;
    endfunction

endpackage

// File: rtl/spi_rate_lane_sel.sv
module spi_rate_lane_sel
    import spi_rate_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [CS_W-1:0]          cs_sel_i,
    input  logic [NUM_CS*CODE_W-1:0] rate_codes_i,
    input  logic [NUM_CS-1:0]        cpol_vec_i,
    input  logic [NUM_CS-1:0]        cpha_vec_i,
    output lane_cfg_t                cfg_o
);

    lane_cfg_t lanes [NUM_CS];

    for (genvar k = 0; k < NUM_CS; k++) begin : g_lane
        always_comb begin
            lanes[k].code = fold_code(rate_codes_i[k*CODE_W +: CODE_W]);
            lanes[k].cpol = cpol_vec_i[k];
            lanes[k].cpha = cpha_vec_i[k];
        end
    end

    always_comb begin
        cfg_o = lanes[0];
        for (int k = 0; k < NUM_CS; k++) begin
            if (cs_sel_i == CS_W'(k)) begin
                cfg_o = lanes[k];
            end
        end
    end

    AST_CODE_ONE_HOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cfg_o.code) == 1); // R5

endmodule

// File: rtl/spi_rate_accum.sv
module spi_rate_accum
    import spi_rate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              carry_o
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step;
    logic [SUM_W-1:0] sum;

    // The code is doubled so that one carry marks one half-period.
    assign step    = {code_i, 1'b0};
    assign sum     = {1'b0, acc_q} + {1'b0, step};
    assign carry_o = run_i & sum[SUM_W-1];

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

    AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (acc_q == '0)); // R10

    AST_NO_BACK_TO_BACK_CARRY: assert property (@(posedge clk) disable iff (rst)
        carry_o |=> !carry_o); // R3

endmodule

// File: rtl/spi_rate_edge.sv
module spi_rate_edge
    import spi_rate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic carry_i,
    input  logic cpol_i,
    input  logic cpha_i,
    output logic sclk_o,
    output logic launch_o,
    output logic capture_o
);

    logic       sclk_q;
    logic       odd_next_q;
    edge_kind_t kind_q;
    edge_kind_t kind_d;

    always_comb begin
        kind_d = EDGE_NONE;
        if (run_i && carry_i) begin
            kind_d = classify_edge(odd_next_q, cpha_i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q     <= 1'b0;
            odd_next_q <= 1'b1;
            kind_q     <= EDGE_NONE;
        end else if (!run_i) begin
            sclk_q     <= cpol_i;
            odd_next_q <= 1'b1;
            kind_q     <= EDGE_NONE;
        end else begin
            kind_q <= kind_d;
            if (carry_i) begin
                sclk_q     <= ~sclk_q;
                odd_next_q <= ~odd_next_q;
            end
        end
    end

    assign sclk_o    = sclk_q;
    assign launch_o  = (kind_q == EDGE_LAUNCH);
    assign capture_o = (kind_q == EDGE_CAPTURE);

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(launch_o && capture_o)); // R9

    AST_STROBE_ON_TRANSITION: assert property (@(posedge clk) disable iff (rst)
        (launch_o || capture_o) |-> (sclk_o != $past(sclk_o))); // R9

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> ((sclk_o == $past(cpol_i)) && !launch_o && !capture_o)); // R2

endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_rate_pkg::*;
#(
    parameter int NUM_CS = 8,
    localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     run_i,
    input  logic [CS_W-1:0]          cs_sel_i,
    input  logic [NUM_CS*CODE_W-1:0] rate_codes_i,
    input  logic [NUM_CS-1:0]        cpol_vec_i,
    input  logic [NUM_CS-1:0]        cpha_vec_i,
    output logic                     sclk_o,
    output logic                     launch_o,
    output logic                     capture_o
);

    lane_cfg_t cfg;
    logic      carry;

    spi_rate_lane_sel #(.NUM_CS(NUM_CS)) i_lane_sel (
        .clk          (clk),
        .rst          (rst),
        .cs_sel_i     (cs_sel_i),
        .rate_codes_i (rate_codes_i),
        .cpol_vec_i   (cpol_vec_i),
        .cpha_vec_i   (cpha_vec_i),
        .cfg_o        (cfg)
    );

    spi_rate_accum i_accum (
        .clk     (clk),
        .rst     (rst),
        .run_i   (run_i),
        .code_i  (cfg.code),
        .carry_o (carry)
    );

    spi_rate_edge i_edge (
        .clk       (clk),
        .rst       (rst),
        .run_i     (run_i),
        .carry_i   (carry),
        .cpol_i    (cfg.cpol),
        .cpha_i    (cfg.cpha),
        .sclk_o    (sclk_o),
        .launch_o  (launch_o),
        .capture_o (capture_o)
    );

    AST_RUN_STOP_RETURNS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $fell(run_i) |=> (sclk_o == $past(cfg.cpol))); // R10

endmodule

// File: tb/test_spi_rate_gen.sv
`timescale 1ns/1ps
module test_spi_rate_gen;

    localparam int NCS = 8;
    localparam int NV  = 7;

    logic           clk = 1'b0;
    logic           rst;
    logic           run;
    logic [2:0]     cs_sel;
    logic [NCS*8-1:0] codes;
    logic [NCS-1:0] cpol_v;
    logic [NCS-1:0] cpha_v;
    logic           sclk, launch, capture;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    spi_rate_gen #(.NUM_CS(NCS)) i_spi_rate_gen (
        .clk(clk), .rst(rst), .run_i(run), .cs_sel_i(cs_sel),
        .rate_codes_i(codes), .cpol_vec_i(cpol_v), .cpha_vec_i(cpha_v),
        .sclk_o(sclk), .launch_o(launch), .capture_o(capture)
    );

    // {slot, raw code, cpol, cpha, expected half-period in cycles}
    typedef struct packed {
        logic [2:0]  slot;
        logic [7:0]  code;
        logic        pol;
        logic        pha;
        logic [15:0] half;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'h80, 1'b0, 1'b0, 16'd2},
        '{3'd1, 8'h01, 1'b1, 1'b0, 16'd256},
        '{3'd2, 8'h08, 1'b0, 1'b1, 16'd32},
        '{3'd3, 8'h60, 1'b1, 1'b1, 16'd4},
        '{3'd5, 8'h00, 1'b0, 1'b0, 16'd256},
        '{3'd7, 8'hFF, 1'b1, 1'b0, 16'd2},
        '{3'd4, 8'h03, 1'b0, 1'b1, 16'd128}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Selected slot gets the vector; every other slot gets the opposite settings.
    task automatic load(input vec_t v);
        for (int k = 0; k < NCS; k++) begin
            codes[k*8 +: 8] = 8'h10;
            cpol_v[k]       = ~v.pol;
            cpha_v[k]       = ~v.pha;
        end
        codes[v.slot*8 +: 8] = v.code;
        cpol_v[v.slot]       = v.pol;
        cpha_v[v.slot]       = v.pha;
        cs_sel               = v.slot;
    endtask

    // Counts rising edges until sclk changes; reports strobes seen on that cycle.
    task automatic wait_edge(output int n, output logic l, output logic c, output bit quiet);
        logic prev;
        prev  = sclk;
        n     = 0;
        l     = 1'b0;
        c     = 1'b0;
        quiet = 1'b1;
        while (n < 2000) begin
            @(posedge clk); #1;
            n++;
            if (sclk != prev) begin
                l = launch;
                c = capture;
                break;
            end
            if (launch || capture) quiet = 1'b0;
        end
    endtask

    initial begin
        #(5ns * 60000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic l, c;
        bit q;

        rst = 1'b1; run = 1'b1; load(VECS[1]);
        repeat (4) @(posedge clk);
        #1;
        // R1: reset forces all outputs low even with run high and polarity 1
        check(sclk == 1'b0 && !launch && !capture, "R1", {sclk, launch, capture}, 0);
        @(negedge clk); rst = 1'b0; run = 1'b0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VECS[i];
            @(negedge clk); run = 1'b0; load(v);
            repeat (3) @(posedge clk);
            #1;
            // R2 R8: idle level follows the selected slot's polarity
            check(sclk == v.pol && !launch && !capture, "R2/R8 idle", sclk, v.pol);
            @(negedge clk); run = 1'b1;
            for (int e = 1; e <= 4; e++) begin
                bit odd;
                wait_edge(n, l, c, q);
                odd = (e % 2) == 1;
                // R4 first edge, R3 later spacing, R5 folded code
                check(n == int'(v.half), (e == 1) ? "R4/R5 first edge" : "R3/R5 half period", n, v.half);
                if (v.pha == 1'b0)
                    check(c == odd && l == !odd, "R6 strobe kind", {l, c}, odd ? 1 : 2);
                else
                    check(l == odd && c == !odd, "R7 strobe kind", {l, c}, odd ? 2 : 1);
                check(q, "R9 no strobe between edges", 0, 1);
            end
        end

        // R10: drop run mid half-period, restart must take a full half-period from edge 1
        @(negedge clk); run = 1'b0; load(VECS[2]);
        @(negedge clk); run = 1'b1;
        repeat (20) @(negedge clk);
        run = 1'b0;
        @(posedge clk); #1;
        check(sclk == VECS[2].pol && !launch && !capture, "R10 idle after stop", sclk, VECS[2].pol);
        @(negedge clk); run = 1'b1;
        wait_edge(n, l, c, q);
        check(n == int'(VECS[2].half), "R10 restart timing", n, VECS[2].half);
        check(l == 1'b1 && c == 1'b0, "R10 edge numbering restarts", {l, c}, 2);

        // R8: switching slot while idle switches the idle level
        @(negedge clk); run = 1'b0; load(VECS[0]);
        cpol_v[6] = 1'b1;
        cs_sel    = 3'd6;
        @(posedge clk); #1;
        check(sclk == 1'b1, "R8 slot switch", sclk, 1);
        @(negedge clk); cs_sel = 3'd0;
        @(posedge clk); #1;
        check(sclk == 1'b0, "R8 slot switch back", sclk, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule